// File: doc/BRIEF.md
# Ethernet Link Status LED Driver

This block turns the status of a 10/100 Ethernet PHY into three active-low indicator pins: full duplex, link with activity, and speed. The link/activity pin is driven low and holds steady while a link is up. A transmit or receive strobe makes it blink: it goes dark for a fixed interval, then stays lit for at least the same interval. A further dark interval follows only if more traffic was seen in the meantime. The intervals are counted in milliseconds from a timebase that divides the core clock.

Each pin is open-drain with an external pull-up. A pin level of 1 means the pin is released and the LED is dark. A pin level of 0 means the pin is pulled low and the LED is lit. Every pin can be handed to a general-purpose I/O function through its own select bit. The bit order is 0 for full duplex, 1 for link/activity and 2 for speed. The integrator sets `CLK_PER_MS` to the number of core clocks in one millisecond and `BLINK_MS` to the interval length in milliseconds (80 by default). One interval therefore lasts `BLINK_MS*CLK_PER_MS` cycles.

Top module: `eth_led_drv`

## Requirements
- R1: After reset, with link down, isolation off, auto-negotiation idle and no select bits set, all three pins read 1.
- R2: With no blink in progress, pin 1 (link/activity) reads 0 while `link_up` is 1 and reads 1 while `link_up` is 0.
- R3: A cycle with `tx_activity` or `rx_activity` high while the link is up and pin 1 is steady starts a blink. Pin 1 reads 1 from the next cycle for exactly `BLINK_MS*CLK_PER_MS` cycles.
- R4: After the dark interval, pin 1 reads 0 for one full interval. If no strobe arrived during either interval, it then stays at 0.
- R5: A strobe during the dark interval or the lit interval, including the last cycle of the lit interval, starts the next dark interval directly after the lit one. A strobe one cycle after the lit interval ends starts a fresh blink one cycle later.
- R6: When `link_up` falls, pin 1 reads 1 at once and any blink is abandoned. When the link returns, pin 1 reads 0 steadily and no blink resumes.
- R7: Activity strobes while the link is down have no effect. When the link comes up afterwards, pin 1 reads 0 with no blink.
- R8: Pin 2 (speed) reads 1 whenever `line_isolate` is 1. Otherwise it reads 0 when `autoneg_busy` is 1, or when both `link_up` and `speed_100` are 1. In all other cases it reads 1.
- R9: Pin 0 (duplex) reads 0 exactly when `link_up` and `full_duplex` are both 1, and reads 1 otherwise.
- R10: When `pin_gpio_sel[i]` is 1, pin i equals `gpio_level[i]` regardless of the LED function, including during a blink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | PHY reports a valid link |
| full_duplex | input | 1 | Link runs full duplex |
| speed_100 | input | 1 | Link runs at 100 Mb/s |
| autoneg_busy | input | 1 | Auto-negotiation in progress |
| line_isolate | input | 1 | PHY isolated from the line |
| tx_activity | input | 1 | One-cycle transmit activity strobe |
| rx_activity | input | 1 | One-cycle receive activity strobe |
| pin_gpio_sel | input | 3 | Per-pin hand-over to the GPIO function |
| gpio_level | input | 3 | Level driven by the GPIO function |
| led_pin_n | output | 3 | Pin levels: [0] duplex, [1] link/activity, [2] speed |

## Verification
The checker assumes that all status inputs are synchronous to `clk`. It also assumes that activity arrives as strobes sampled once per clock, so a pin cannot stay dark with the link up for longer than one interval. It holds a pin handed to the GPIO function to the GPIO level only in the same cycle, since that path is combinational. The stimulus changes every input just after a falling edge and samples the pins just before changing them. Strobes are single-cycle, and the select bits are changed only between the interval checks.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

    localparam int unsigned NUM_LED = 3;
    localparam int unsigned LED_DUP = 0;
    localparam int unsigned LED_LNK = 1;
    localparam int unsigned LED_SPD = 2;

    typedef enum logic [1:0] {
        BL_STEADY = 2'd0,
        BL_DARK   = 2'd1,
        BL_HOLD   = 2'd2
    } blink_st_e;

endpackage

// File: rtl/led_ms_timebase.sv
module led_ms_timebase #(
    parameter int unsigned CLK_PER_MS = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick
);
    localparam int unsigned CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    assign ms_tick = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (restart || ms_tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/led_act_blink.sv
module led_act_blink
    import eth_led_pkg::*;
#(
    parameter int unsigned BLINK_MS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic act,
    input  logic ms_tick,
    output logic restart,
    output logic dark
);
    localparam int unsigned MW = $clog2(BLINK_MS + 1);
    localparam logic [MW-1:0] MS_LAST = MW'(BLINK_MS - 1);

    typedef struct packed {
        blink_st_e      st;
        logic           pend;
        logic [MW-1:0]  ms;
    } bl_state_t;

    bl_state_t bl_d, bl_q;
    logic      last_ms;

    assign last_ms = ms_tick && (bl_q.ms == MS_LAST);
    assign dark    = (bl_q.st == BL_DARK);

    always_comb begin
        bl_d    = bl_q;
        restart = 1'b0;
        if (!link_up) begin
            bl_d.st   = BL_STEADY;
            bl_d.pend = 1'b0;
            bl_d.ms   = '0;
        end else begin
            case (bl_q.st)
                BL_STEADY: begin
                    if (act) begin
                        bl_d.st   = BL_DARK;
                        bl_d.pend = 1'b0;
                        bl_d.ms   = '0;
                        restart   = 1'b1;
                    end
                end
                BL_DARK: begin
                    if (act)     bl_d.pend = 1'b1;
                    if (ms_tick) bl_d.ms   = bl_q.ms + MW'(1);
                    if (last_ms) begin
                        bl_d.st = BL_HOLD;
                        bl_d.ms = '0;
                        restart = 1'b1;
                    end
                end
                BL_HOLD: begin
                    if (act)     bl_d.pend = 1'b1;
                    if (ms_tick) bl_d.ms   = bl_q.ms + MW'(1);
                    if (last_ms) begin
                        bl_d.ms   = '0;
                        bl_d.pend = 1'b0;
                        if (bl_q.pend || act) begin
                            bl_d.st = BL_DARK;
                            restart = 1'b1;
                        end else begin
                            bl_d.st = BL_STEADY;
                        end
                    end
                end
                default: begin
                    bl_d.st   = BL_STEADY;
                    bl_d.pend = 1'b0;
                    bl_d.ms   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bl_q.st   <= BL_STEADY;
            bl_q.pend <= 1'b0;
            bl_q.ms   <= '0;
        end else begin
            bl_q <= bl_d;
        end
    end

endmodule

// File: rtl/eth_led_drv.sv
module eth_led_drv
    import eth_led_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 25000,
    parameter int unsigned BLINK_MS   = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         link_up,
    input  logic         full_duplex,
    input  logic         speed_100,
    input  logic         autoneg_busy,
    input  logic         line_isolate,
    input  logic         tx_activity,
    input  logic         rx_activity,
    input  logic [2:0]   pin_gpio_sel,
    input  logic [2:0]   gpio_level,
    output logic [2:0]   led_pin_n
);
    logic             ms_tick;
    logic             restart;
    logic             dark;
    logic [NUM_LED-1:0] func_n;

    led_ms_timebase #(.CLK_PER_MS(CLK_PER_MS)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ms_tick (ms_tick)
    );

    led_act_blink #(.BLINK_MS(BLINK_MS)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .act     (tx_activity | rx_activity),
        .ms_tick (ms_tick),
        .restart (restart),
        .dark    (dark)
    );

    always_comb begin
        func_n          = '1;
        func_n[LED_DUP] = ~(link_up & full_duplex);
        func_n[LED_LNK] = ~link_up | dark;
        func_n[LED_SPD] = line_isolate | ~(autoneg_busy | (link_up & speed_100));
    end

    for (genvar gi = 0; gi < NUM_LED; gi++) begin : g_pin
        assign led_pin_n[gi] = pin_gpio_sel[gi] ? gpio_level[gi] : func_n[gi];
    end

endmodule

// File: rtl/eth_led_drv_chk.sv
module eth_led_drv_chk #(
    parameter int unsigned CLK_PER_MS = 25000,
    parameter int unsigned BLINK_MS   = 80
) (
    input logic       clk,
    input logic       rst_n,
    input logic       link_up,
    input logic       full_duplex,
    input logic       autoneg_busy,
    input logic       line_isolate,
    input logic [2:0] pin_gpio_sel,
    input logic [2:0] gpio_level,
    input logic [2:0] led_pin_n
);
    localparam int unsigned OFF_CYC = BLINK_MS * CLK_PER_MS;

    logic [31:0] dark_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dark_run <= '0;
        end else if (link_up && !pin_gpio_sel[1] && led_pin_n[1]) begin
            dark_run <= dark_run + 32'd1;
        end else begin
            dark_run <= '0;
        end
    end

    a_r2_link_down_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !pin_gpio_sel[1]) |-> led_pin_n[1]);

    a_r3_dark_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        dark_run <= OFF_CYC);

    a_r8_isolate_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (line_isolate && !pin_gpio_sel[2]) |-> led_pin_n[2]);

    a_r8_autoneg_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (autoneg_busy && !line_isolate && !pin_gpio_sel[2]) |-> !led_pin_n[2]);

    a_r9_duplex_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && full_duplex && !pin_gpio_sel[0]) |-> !led_pin_n[0]);

    a_r10_gpio_owns_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_gpio_sel) |-> (((led_pin_n ^ gpio_level) & pin_gpio_sel) == 3'b000));

endmodule

bind eth_led_drv eth_led_drv_chk #(
    .CLK_PER_MS (CLK_PER_MS),
    .BLINK_MS   (BLINK_MS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up      (link_up),
    .full_duplex  (full_duplex),
    .autoneg_busy (autoneg_busy),
    .line_isolate (line_isolate),
    .pin_gpio_sel (pin_gpio_sel),
    .gpio_level   (gpio_level),
    .led_pin_n    (led_pin_n)
);

// File: tb/eth_led_drv_bench.sv
module eth_led_drv_bench;
    localparam int unsigned P  = 3;
    localparam int unsigned BL = 4;
    localparam int T = P * BL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_up = 1'b0, full_duplex = 1'b0, speed_100 = 1'b0;
    logic       autoneg_busy = 1'b0, line_isolate = 1'b0;
    logic       tx_activity = 1'b0, rx_activity = 1'b0;
    logic [2:0] pin_gpio_sel = 3'b000, gpio_level = 3'b000;
    logic [2:0] led_pin_n;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    eth_led_drv #(.CLK_PER_MS(P), .BLINK_MS(BL)) u_eth_led_drv (
        .clk, .rst_n, .link_up, .full_duplex, .speed_100, .autoneg_busy,
        .line_isolate, .tx_activity, .rx_activity, .pin_gpio_sel,
        .gpio_level, .led_pin_n
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, exp);
        end
    endtask

    // Walks one activity scenario, checking pin 1 each cycle before driving.
    task automatic blink_case(input int a0, input int a1, input int lo_at,
                              input int hi_at, input int w0s, input int w0e,
                              input int w1s, input int w1e, input int len,
                              input string req);
        for (int k = 0; k <= len; k++) begin
            @(negedge clk);
            if (k > 0) begin
                check(led_pin_n[1],
                      !link_up || (k >= w0s && k <= w0e) || (k >= w1s && k <= w1e),
                      req);
            end
            tx_activity = (k == a0);
            rx_activity = (k == a1);
            if (k == lo_at) link_up = 1'b0;
            if (k == hi_at) link_up = 1'b1;
        end
        tx_activity = 1'b0;
        rx_activity = 1'b0;
        repeat (3 * T) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(led_pin_n[0], 1'b1, "R1 duplex");
        check(led_pin_n[1], 1'b1, "R1 link");
        check(led_pin_n[2], 1'b1, "R1 speed");

        // Exhaustive sweep of the static status inputs (R2, R8, R9)
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            link_up      = v[0];
            full_duplex  = v[1];
            speed_100    = v[2];
            autoneg_busy = v[3];
            line_isolate = v[4];
            @(negedge clk);
            check(led_pin_n[0], !(v[0] && v[1]), "R9");
            check(led_pin_n[2], v[4] || !(v[3] || (v[0] && v[2])), "R8");
            check(led_pin_n[1], !v[0], "R2");
        end

        @(negedge clk);
        link_up = 1'b1; full_duplex = 1'b0; speed_100 = 1'b0;
        autoneg_busy = 1'b0; line_isolate = 1'b0;
        repeat (3 * T) @(negedge clk);

        // R3/R4: single rx strobe, one dark interval then steady
        blink_case(-1, 0, -1, -1, 1, T, -9, -9, 5 * T, "R3_R4 single");
        // R5: pending from the dark interval
        blink_case(0, 5, -1, -1, 1, T, 2*T+1, 3*T, 5 * T, "R5 pend_dark");
        // R5: pending from the lit interval
        blink_case(0, T+3, -1, -1, 1, T, 2*T+1, 3*T, 5 * T, "R5 pend_hold");
        // R5: strobe on the last lit cycle
        blink_case(0, 2*T, -1, -1, 1, T, 2*T+1, 3*T, 5 * T, "R5 last_cycle");
        // R5: strobe just after the lit interval starts a fresh blink
        blink_case(0, 2*T+1, -1, -1, 1, T, 2*T+2, 3*T+1, 5 * T, "R5 after_hold");
        // R6: link drops during dark interval and returns
        blink_case(0, -1, 3, 5, 1, 3, -9, -9, 4 * T, "R6 link_drop");
        // R7: activity with link down
        @(negedge clk);
        link_up = 1'b0;
        blink_case(0, 1, -1, 2, -9, -9, -9, -9, 3 * T, "R7 no_link");

        // R10: every GPIO level on fully handed-over pins
        for (int g = 0; g < 8; g++) begin
            @(negedge clk);
            pin_gpio_sel = 3'b111;
            gpio_level   = 3'(g);
            @(negedge clk);
            for (int b = 0; b < 3; b++) check(led_pin_n[b], gpio_level[b], "R10 sweep");
        end
        // R10: pin 1 handed over in the middle of a blink
        @(negedge clk);
        pin_gpio_sel = 3'b000;
        tx_activity  = 1'b1;
        @(negedge clk);
        tx_activity  = 1'b0;
        check(led_pin_n[1], 1'b1, "R3 blink_start");
        pin_gpio_sel = 3'b010;
        gpio_level   = 3'b000;
        @(negedge clk);
        check(led_pin_n[1], 1'b0, "R10 during_blink");
        check(led_pin_n[0], 1'b1, "R10 other_pin");
        pin_gpio_sel = 3'b000;
        repeat (3 * T) @(negedge clk);
        check(led_pin_n[1], 1'b0, "R4 steady_after");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule